// File: doc/BRIEF.md
# 1553B Manchester Word Encoder

This block turns one 16-bit payload into a complete serial word for a MIL-STD-1553B bus. The word has a sync of three bit-times, sixteen Manchester II data bits sent most significant bit first, and an odd parity bit. That is 20 bit-times, or 40 half-bits, at 1 Mbit/s. The block drives a complementary pair of transmit lines and an inhibit line. The inhibit line is asserted whenever no word is being sent.

The system clock runs at one of four rates: 12, 16, 20 or 24 MHz. A two-bit select input tells the block which rate is in use, and the block counts the clocks in each half-bit from it. A producer offers words with a valid/ready handshake. If the next word is already offered during the last clock of the parity bit, it is accepted at that edge and its sync follows with no idle gap. A one-cycle done pulse marks the end of each word.

The controller has four states:
- IDLE: bus quiet.
- SYNC: half-bits 0..5.
- DATA: half-bits 6..37.
- PARITY: half-bits 38..39.

The transitions are:
- IDLE→SYNC on a handshake.
- SYNC→DATA at the end of half-bit 5.
- DATA→PARITY at the end of half-bit 37.
- PARITY→SYNC at the end of half-bit 39 if a handshake occurs in that same clock.
- PARITY→IDLE at the end of half-bit 39 otherwise.

Top module: `mil_word_encoder`

## Requirements
- R1: After reset and whenever no word is in progress, tx_pos=0, tx_neg=0, tx_inhibit=1, req_ready=1 and word_done=0.
- R2: Each half-bit lasts 6, 8, 10 or 12 clocks for clk_sel = 0, 1, 2 or 3, which stand for 12, 16, 20 and 24 MHz. A word lasts exactly 40 half-bits.
- R3: For a command/status word (req_is_data=0), tx_pos is high for the first three half-bits and low for the next three. For a data word (req_is_data=1), the sync is the inverse: three half-bits low, then three high.
- R4: Data bits go out from req_data[15] down to req_data[0]. A 1 is sent as tx_pos high then low, and a 0 as low then high.
- R5: The final bit is odd parity over the 16 payload bits, so the 16 bits plus parity hold an odd number of ones. It is encoded like a data bit.
- R6: While a word is in progress, tx_inhibit=0 and tx_neg is the complement of tx_pos. The two drive lines are never both high.
- R7: req_ready is high in IDLE and in the final clock of the parity bit, and low otherwise. A word is accepted on a clock edge with req_valid and req_ready both high. Its first sync half-bit appears in the very next cycle.
- R8: A word accepted during the final clock of the previous word starts in the next cycle, with no idle cycle between the two words.
- R9: word_done is high for exactly one cycle, the cycle after the final clock of the parity bit.
- R10: clk_sel is sampled only at acceptance. Changing it during a word does not alter that word's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12/16/20/24 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Clock rate code: 0=12, 1=16, 2=20, 3=24 MHz |
| req_valid | input | 1 | A word is offered |
| req_data | input | 16 | Payload of the offered word |
| req_is_data | input | 1 | 1 = data sync, 0 = command/status sync |
| req_ready | output | 1 | Block accepts the offered word this cycle |
| tx_pos | output | 1 | Positive drive line |
| tx_neg | output | 1 | Negative drive line |
| tx_inhibit | output | 1 | Transmitter inhibit, high while idle |
| word_done | output | 1 | One-cycle pulse after the parity bit |

## Verification
The bench sends words of both sync types at every clock-rate code, using payloads that separate the encodings:
- All zeros and all ones give even popcounts, so parity is 1.
- A single set bit gives parity 0 and shows whether bit order is reversed.
- A mixed pattern exposes swapped half-bit polarity.

A run of three words offered back to back distinguishes a zero-gap restart from one that inserts an idle cycle. One word has its rate code changed partway through, which shows whether the rate is latched at acceptance or tracked live. Every clock is compared with a behavioural model, so a half-bit that is one clock too long or too short is caught at the exact cycle.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_DATA   = 2'd2,
        ST_PARITY = 2'd3
    } enc_state_t;

    // Half-bits in the sync field (three bit-times).
    localparam int unsigned SYNC_HALVES = 6;

    function automatic int unsigned word_halves(input int unsigned payload_bits);
        return SYNC_HALVES + 2 * (payload_bits + 1);
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/mwe_rate_sel.sv
module mwe_rate_sel #(
    parameter int unsigned HALF_A = 6,
    parameter int unsigned HALF_B = 8,
    parameter int unsigned HALF_C = 10,
    parameter int unsigned HALF_D = 12,
    parameter int unsigned CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] half_len
);
    logic [CNT_W-1:0] len_next;

    // Map the rate code to clocks per half-bit.
    always_comb begin
        unique case (sel)
            2'd0: len_next = CNT_W'(HALF_A);
            2'd1: len_next = CNT_W'(HALF_B);
            2'd2: len_next = CNT_W'(HALF_C);
            2'd3: len_next = CNT_W'(HALF_D);
            default: len_next = CNT_W'(HALF_A);
        endcase
    end

    // Latched only when a word is accepted, so the rate is fixed for the whole word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            half_len <= CNT_W'(HALF_A);
        else if (load)
            half_len <= len_next;
    end
endmodule

// File: rtl/mwe_halfbit_timer.sv
module mwe_halfbit_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] half_len,
    output logic             half_end
);
    logic [CNT_W-1:0] cnt;

    assign half_end = run && (cnt == half_len - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (run) begin
            if (half_end)
                cnt <= '0;
            else
                cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mwe_frame_builder.sv
module mwe_frame_builder #(
    parameter int unsigned PAYLOAD_BITS = 16,
    parameter int unsigned HALVES       = 40
) (
    input  logic [PAYLOAD_BITS-1:0] payload,
    input  logic                    is_data,
    output logic [HALVES-1:0]       pattern
);
    import mwe_pkg::*;

    localparam int unsigned SYNC_HALF = SYNC_HALVES / 2;
    localparam int unsigned PAR_POS   = SYNC_HALVES + 2 * PAYLOAD_BITS;

    logic odd_par;
    assign odd_par = ~(^payload);

    // Index 0 of pattern is the first half-bit on the line.
    genvar g;
    generate
        for (g = 0; g < SYNC_HALVES; g++) begin : g_sync
            if (g < SYNC_HALF) begin : g_first
                assign pattern[g] = ~is_data;
            end else begin : g_second
                assign pattern[g] = is_data;
            end
        end
        for (g = 0; g < PAYLOAD_BITS; g++) begin : g_bit
            assign pattern[SYNC_HALVES + 2*g]     =  payload[PAYLOAD_BITS-1-g];
            assign pattern[SYNC_HALVES + 2*g + 1] = ~payload[PAYLOAD_BITS-1-g];
        end
    endgenerate

    assign pattern[PAR_POS]     =  odd_par;
    assign pattern[PAR_POS + 1] = ~odd_par;
endmodule

// File: rtl/mil_word_encoder.sv
module mil_word_encoder #(
    parameter int unsigned PAYLOAD_BITS = 16,
    parameter int unsigned HALF_AT_12   = 6,
    parameter int unsigned HALF_AT_16   = 8,
    parameter int unsigned HALF_AT_20   = 10,
    parameter int unsigned HALF_AT_24   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              clk_sel,
    input  logic                    req_valid,
    input  logic [PAYLOAD_BITS-1:0] req_data,
    input  logic                    req_is_data,
    output logic                    req_ready,
    output logic                    tx_pos,
    output logic                    tx_neg,
    output logic                    tx_inhibit,
    output logic                    word_done
);
    import mwe_pkg::*;

    localparam int unsigned HALVES   = word_halves(PAYLOAD_BITS);
    localparam int unsigned MAX_HALF = max4(HALF_AT_12, HALF_AT_16, HALF_AT_20, HALF_AT_24);
    localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);
    localparam int unsigned IDX_W    = $clog2(HALVES);
    localparam logic [IDX_W-1:0] SYNC_LAST = IDX_W'(SYNC_HALVES - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(HALVES - 3);
    localparam logic [IDX_W-1:0] WORD_LAST = IDX_W'(HALVES - 1);

    enc_state_t        state_q, state_d;
    logic [HALVES-1:0] pattern_q, pattern_d;
    logic [IDX_W-1:0]  hb_idx;
    logic [CNT_W-1:0]  half_len;
    logic              half_end;
    logic              accept;
    logic              last_cycle;
    logic              cur_half;
    logic              done_q;

    mwe_rate_sel #(
        .HALF_A(HALF_AT_12), .HALF_B(HALF_AT_16),
        .HALF_C(HALF_AT_20), .HALF_D(HALF_AT_24), .CNT_W(CNT_W)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .load(accept), .sel(clk_sel), .half_len(half_len)
    );

    mwe_halfbit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE),
        .restart(accept), .half_len(half_len), .half_end(half_end)
    );

    mwe_frame_builder #(.PAYLOAD_BITS(PAYLOAD_BITS), .HALVES(HALVES)) u_build (
        .payload(req_data), .is_data(req_is_data), .pattern(pattern_d)
    );

    assign last_cycle = (state_q == ST_PARITY) && half_end && (hb_idx == WORD_LAST);
    assign req_ready  = (state_q == ST_IDLE) || last_cycle;
    assign accept     = req_valid && req_ready;
    assign cur_half   = pattern_q[hb_idx];

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SYNC;
            ST_SYNC:   if (half_end && hb_idx == SYNC_LAST) state_d = ST_DATA;
            ST_DATA:   if (half_end && hb_idx == DATA_LAST) state_d = ST_PARITY;
            ST_PARITY: if (last_cycle) state_d = accept ? ST_SYNC : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Half-bit index, latched word pattern and the done pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern_q <= '0;
            hb_idx    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= last_cycle;
            if (accept) begin
                pattern_q <= pattern_d;
                hb_idx    <= '0;
            end else if (half_end && hb_idx != WORD_LAST) begin
                hb_idx <= hb_idx + IDX_W'(1);
            end
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                tx_pos     = 1'b0;
                tx_neg     = 1'b0;
                tx_inhibit = 1'b1;
            end
            default: begin
                tx_pos     = cur_half;
                tx_neg     = ~cur_half;
                tx_inhibit = 1'b0;
            end
        endcase
    end

    assign word_done = done_q;
endmodule

// File: rtl/mil_word_encoder_chk.sv
module mil_word_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic tx_pos,
    input logic tx_neg,
    input logic tx_inhibit,
    input logic word_done
);
    // R6
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pos && tx_neg));

    // R1
    quiet_when_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> (!tx_pos && !tx_neg && req_ready));

    // R6
    active_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_inhibit |-> (tx_pos != tx_neg));

    // R7
    start_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_inhibit && req_valid && req_ready) |=> !tx_inhibit);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_done) |-> $past(req_ready && !tx_inhibit));
endmodule

bind mil_word_encoder mil_word_encoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_inhibit(tx_inhibit), .word_done(word_done)
);

// File: tb/tb_mil_word_encoder.sv
module tb_mil_word_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic [15:0] req_data = 16'h0;
    logic        req_is_data = 1'b0;
    logic        req_ready, tx_pos, tx_neg, tx_inhibit, word_done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit done_due = 1'b0;
    string tag_override = "";

    typedef struct {
        bit    pos;
        bit    last;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    mil_word_encoder dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .req_valid(req_valid),
        .req_data(req_data), .req_is_data(req_is_data), .req_ready(req_ready),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_inhibit(tx_inhibit), .word_done(word_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Behavioural model: the expected tx_pos for every clock of the word (R2-R5).
    task automatic push_word(input logic [15:0] d, input bit is_data, input logic [1:0] sel,
                             input bit busy);
        int len;
        bit halves[$];
        bit par;
        len = 6 + 2 * int'(sel);
        par = 1'b1;
        for (int i = 0; i < 3; i++) halves.push_back(!is_data);
        for (int i = 0; i < 3; i++) halves.push_back(is_data);
        for (int b = 15; b >= 0; b--) begin
            halves.push_back(d[b]);
            halves.push_back(!d[b]);
            if (d[b]) par = !par;
        end
        halves.push_back(par);
        halves.push_back(!par);
        for (int h = 0; h < halves.size(); h++) begin
            for (int c = 0; c < len; c++) begin
                exp_t e;
                e.pos  = halves[h];
                e.last = (h == halves.size() - 1) && (c == len - 1);
                if (tag_override != "") e.tag = tag_override;
                else if (busy && h == 0 && c == 0) e.tag = "R8";
                else if (h < 6) e.tag = "R3";
                else if (h < 38) e.tag = "R4";
                else e.tag = "R5";
                q.push_back(e);
            end
        end
    endtask

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
        if (model_on) begin
            bit have;
            exp_t e;
            have = q.size() > 0;
            if (have) begin
                e = q[0];
                chk(e.tag, tx_pos, e.pos);
                chk("R6", tx_neg, !e.pos);
                chk("R6", tx_inhibit, 0);
                chk("R7", req_ready, e.last);
            end else begin
                chk("R1", tx_pos, 0);
                chk("R1", tx_neg, 0);
                chk("R1", tx_inhibit, 1);
                chk("R1", req_ready, 1);
            end
            chk("R9", word_done, done_due);
            done_due = have && e.last;
            if (req_valid && req_ready) push_word(req_data, req_is_data, clk_sel, have);
            if (have) void'(q.pop_front());
        end
    end

    task automatic send(input logic [15:0] d, input bit is_data, input logic [1:0] sel);
        clk_sel     = sel;
        req_data    = d;
        req_is_data = is_data;
        req_valid   = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        while (q.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", tx_inhibit, 1);
        chk("R1", tx_pos, 0);
        chk("R1", tx_neg, 0);
        chk("R1", req_ready, 1);
        chk("R1", word_done, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        model_on = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // R2..R5: each rate code, both sync types, distinct payloads
        send(16'hA5C3, 1'b0, 2'd0); go_idle();
        send(16'h0000, 1'b1, 2'd1); go_idle();
        send(16'hFFFF, 1'b0, 2'd2); go_idle();
        send(16'h0001, 1'b1, 2'd3); go_idle();
        send(16'h8000, 1'b0, 2'd1); go_idle();

        // R8: three words back to back
        send(16'h1234, 1'b0, 2'd3);
        send(16'h5678, 1'b1, 2'd3);
        send(16'h9ABC, 1'b1, 2'd0);
        go_idle();

        // R10: rate code changes mid-word and must not alter the word
        tag_override = "R10";
        send(16'h3C3C, 1'b1, 2'd0);
        tag_override = "";
        req_valid = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        clk_sel = 2'd3;
        go_idle();

        model_on = 1'b0;
        finish_run();
    end
endmodule